// File: doc/BRIEF.md
# Clock Pulse Skipper

This block produces a per-cycle clock-enable that suppresses a programmed share of clock pulses, so that a downstream clock gate runs its domain at a reduced effective rate. The skip depth is given in one of two ways: directly as a percentage of pulses to drop, or as a two-bit coded step that selects one of four fixed percentages. A status output reports the depth in force.

Time is divided into aligned windows of 100 cycles. The depth is sampled only on the last cycle of a window and is applied to the whole of the following window. This keeps each window at a single depth. Inside a window the kept pulses are spread evenly by an accumulator. The keep share (100 minus depth) is added every cycle. The enable is raised whenever the running sum reaches 100, and 100 is then taken off.

A small state machine holds the window mode. It has three states:
- `ST_FULL`: depth 0, enable held high.
- `ST_SKIP`: fractional depth, enable driven by the accumulator.
- `ST_STOP`: depth 100, enable held low.

On the last cycle of each window the machine takes one of three transitions. It goes to `ST_FULL` when the incoming depth is 0, to `ST_STOP` when it is 100, and to `ST_SKIP` otherwise. The transition is taken from any state, including back into the same state. Reset enters `ST_FULL` at window phase 0.

Top module: `pskip_top`

## Requirements
- R1: While reset is asserted and after it is released, the block is in `ST_FULL` at window phase 0, with `clk_en_o` high and `depth_o` equal to 0.
- R2: With `mode_i` = 0 (percentage mode), the depth applied is `pct_i`. Any `pct_i` value above 100 is saturated to 100.
- R3: With `mode_i` = 1 (level mode), `lvl_i` selects the depth as follows: 0 gives 0, 1 gives 50, 2 gives 75 and 3 gives 85 percent skipped.
- R4: Over every aligned 100-cycle window, the number of cycles with `clk_en_o` high equals exactly 100 minus the applied depth.
- R5: Kept pulses are spread evenly. In window phase k (0..99) with keep share K = 100 - depth, `clk_en_o` is high exactly when floor((k+1)·K/100) exceeds floor(k·K/100).
- R6: The inputs are sampled only in the last cycle of a window (phase 99). A change at any other phase has no effect on `depth_o` or `clk_en_o` until the next window begins.
- R7: An applied depth of 100 holds `clk_en_o` low for the whole window. An applied depth of 0 holds it high.
- R8: `depth_o` reports the depth applied in the current window and never exceeds 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the domain being thinned |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Depth source select: 0 = percentage, 1 = coded level |
| pct_i | input | 7 | Percentage of pulses to skip (saturated at 100) |
| lvl_i | input | 2 | Coded depth step (0/50/75/85 percent) |
| clk_en_o | output | 1 | Per-cycle enable for the downstream clock gate |
| depth_o | output | 7 | Depth applied in the current window |

## Verification
`clk_en_o` and `depth_o` are decoded combinationally from registered state. Each value therefore belongs to the cycle between two rising edges, and the bench compares both on every falling edge against a behavioural model that advances on the rising edge. A new depth on the inputs shows up on `depth_o` and `clk_en_o` one edge after the window's phase-99 cycle, which is the first cycle of the next window, and the model applies it at that same edge. Input changes are deliberately made in mid-window so that the deferral is visible. At phase 99 the bench also totals the enables seen over the window and compares the total with 100 minus the depth.

// File: rtl/pskip_pkg.sv
package pskip_pkg;

    typedef enum logic [1:0] {
        ST_FULL = 2'd0,
        ST_SKIP = 2'd1,
        ST_STOP = 2'd2
    } pskip_state_e;

    typedef enum logic {
        SRC_PCT = 1'b0,
        SRC_LVL = 1'b1
    } pskip_src_e;

endpackage

// File: rtl/pskip_depth_sel.sv
module pskip_depth_sel
    import pskip_pkg::*;
#(
    parameter int unsigned WIN_LEN = 100,
    parameter int unsigned DEPTH_W = $clog2(WIN_LEN + 1),
    parameter int unsigned LVL1_PCT = 50,
    parameter int unsigned LVL2_PCT = 75,
    parameter int unsigned LVL3_PCT = 85
) (
    input  logic               mode_i,
    input  logic [DEPTH_W-1:0] pct_i,
    input  logic [1:0]         lvl_i,
    output logic [DEPTH_W-1:0] depth_o
);

    localparam int unsigned NUM_LVL = 4;
    localparam int unsigned LVL_PCT [NUM_LVL] = '{0, LVL1_PCT, LVL2_PCT, LVL3_PCT};

    logic [NUM_LVL-1:0][DEPTH_W-1:0] lvl_lut;
    logic [DEPTH_W-1:0]              pct_sat;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lut
        localparam int unsigned CLIPPED = (LVL_PCT[g] > WIN_LEN) ? WIN_LEN : LVL_PCT[g];
        assign lvl_lut[g] = DEPTH_W'(CLIPPED);
    end

    always_comb begin
        if (pct_i > DEPTH_W'(WIN_LEN)) begin
            pct_sat = DEPTH_W'(WIN_LEN);
        end else begin
            pct_sat = pct_i;
        end
    end

    always_comb begin
        unique case (pskip_src_e'(mode_i))
            SRC_PCT: depth_o = pct_sat;
            SRC_LVL: depth_o = lvl_lut[lvl_i];
            default: depth_o = '0;
        endcase
    end

endmodule

// File: rtl/pskip_window.sv
module pskip_window #(
    parameter int unsigned WIN_LEN = 100,
    parameter int unsigned PH_W = $clog2(WIN_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);

    logic [PH_W-1:0] phase_q;

    assign last_o  = (phase_q == PH_W'(WIN_LEN - 1));
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (last_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/pskip_accum.sv
module pskip_accum #(
    parameter int unsigned WIN_LEN = 100,
    parameter int unsigned DEPTH_W = $clog2(WIN_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic [DEPTH_W-1:0] keep_i,
    output logic               hit_o
);

    localparam int unsigned SUM_W = DEPTH_W + 1;

    logic [DEPTH_W-1:0] acc_q;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   rem;

    assign sum   = {1'b0, acc_q} + {1'b0, keep_i};
    assign hit_o = (sum >= SUM_W'(WIN_LEN));
    assign rem   = hit_o ? (sum - SUM_W'(WIN_LEN)) : sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= rem[DEPTH_W-1:0];
        end
    end

endmodule

// File: rtl/pskip_top.sv
module pskip_top
    import pskip_pkg::*;
#(
    parameter int unsigned WIN_LEN = 100,
    parameter int unsigned DEPTH_W = $clog2(WIN_LEN + 1),
    parameter int unsigned LVL1_PCT = 50,
    parameter int unsigned LVL2_PCT = 75,
    parameter int unsigned LVL3_PCT = 85
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i,
    input  logic [DEPTH_W-1:0] pct_i,
    input  logic [1:0]         lvl_i,
    output logic               clk_en_o,
    output logic [DEPTH_W-1:0] depth_o
);

    localparam int unsigned PH_W = $clog2(WIN_LEN);

    pskip_state_e       state_q;
    pskip_state_e       state_nxt;
    logic [DEPTH_W-1:0] depth_q;
    logic [DEPTH_W-1:0] depth_req;
    logic [DEPTH_W-1:0] keep;
    logic [PH_W-1:0]    phase;
    logic               win_last;
    logic               acc_hit;

    pskip_depth_sel #(
        .WIN_LEN (WIN_LEN),
        .DEPTH_W (DEPTH_W),
        .LVL1_PCT(LVL1_PCT),
        .LVL2_PCT(LVL2_PCT),
        .LVL3_PCT(LVL3_PCT)
    ) u_sel (
        .mode_i (mode_i),
        .pct_i  (pct_i),
        .lvl_i  (lvl_i),
        .depth_o(depth_req)
    );

    pskip_window #(
        .WIN_LEN(WIN_LEN),
        .PH_W   (PH_W)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_o(phase),
        .last_o (win_last)
    );

    assign keep = DEPTH_W'(WIN_LEN) - depth_q;

    pskip_accum #(
        .WIN_LEN(WIN_LEN),
        .DEPTH_W(DEPTH_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(win_last),
        .keep_i   (keep),
        .hit_o    (acc_hit)
    );

    // Next window mode, chosen from the requested depth
    always_comb begin
        if (depth_req == '0) begin
            state_nxt = ST_FULL;
        end else if (depth_req == DEPTH_W'(WIN_LEN)) begin
            state_nxt = ST_STOP;
        end else begin
            state_nxt = ST_SKIP;
        end
    end

    // State register: updated only at the window boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            depth_q <= '0;
        end else if (win_last) begin
            state_q <= state_nxt;
            depth_q <= depth_req;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_FULL: clk_en_o = 1'b1;
            ST_SKIP: clk_en_o = acc_hit;
            ST_STOP: clk_en_o = 1'b0;
            default: clk_en_o = 1'b0;
        endcase
        depth_o = depth_q;
    end

    logic unused_phase;
    assign unused_phase = ^phase;

endmodule

// File: rtl/pskip_chk.sv
module pskip_chk #(
    parameter int unsigned WIN_LEN = 100,
    parameter int unsigned DEPTH_W = $clog2(WIN_LEN + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clk_en_o,
    input logic [DEPTH_W-1:0] depth_o
);

    int unsigned cnt;
    int unsigned en_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= 0;
            en_cnt <= 0;
        end else if (cnt == WIN_LEN - 1) begin
            AST_WINDOW_TOTAL: assert (en_cnt + int'(clk_en_o) == WIN_LEN - int'(depth_o)); // R4
            cnt    <= 0;
            en_cnt <= 0;
        end else begin
            cnt    <= cnt + 1;
            en_cnt <= en_cnt + int'(clk_en_o);
        end
    end

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == DEPTH_W'(WIN_LEN)) |-> !clk_en_o); // R7

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o == '0) |-> clk_en_o); // R7

    AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DEPTH_W'(WIN_LEN)); // R8

    AST_HOLD_MIDWIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != WIN_LEN - 1) |=> $stable(depth_o)); // R6

endmodule

bind pskip_top pskip_chk #(
    .WIN_LEN(WIN_LEN),
    .DEPTH_W(DEPTH_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en_o(clk_en_o),
    .depth_o (depth_o)
);

// File: tb/pskip_top_bench.sv
module pskip_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic [6:0] pct_i = '0;
    logic [1:0] lvl_i = '0;
    logic       clk_en_o;
    logic [6:0] depth_o;

    int checks = 0;
    int fails = 0;
    int m_phase = 0;
    int m_depth = 0;
    int win_en = 0;
    string m_src = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    pskip_top u_pskip_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .pct_i   (pct_i),
        .lvl_i   (lvl_i),
        .clk_en_o(clk_en_o),
        .depth_o (depth_o)
    );

    function automatic int want_depth(logic m, logic [6:0] p, logic [1:0] l);
        if (m) begin
            case (l)
                2'd0: return 0;
                2'd1: return 50;
                2'd2: return 75;
                default: return 85;
            endcase
        end
        return (p > 100) ? 100 : int'(p);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (phase %0d)", req, act, exp, m_phase);
        end
    endtask

    // Reference model, advanced on the rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_depth = 0;
            m_src   = "R1";
        end else if (m_phase == 99) begin
            m_phase = 0;
            m_depth = want_depth(mode_i, pct_i, lvl_i);
            m_src   = mode_i ? "R3" : "R2";
        end else begin
            m_phase = m_phase + 1;
        end
    end

    // Compare on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int keep;
            int exp_en;
            string dtag;
            keep   = 100 - m_depth;
            exp_en = ((m_phase + 1) * keep) / 100 - (m_phase * keep) / 100;
            check((m_depth == 0 || m_depth == 100) ? "R7" : "R5", int'(clk_en_o), exp_en);
            if (m_phase == 0) dtag = m_src;
            else if (m_phase == 50) dtag = "R8";
            else dtag = "R6";
            check(dtag, int'(depth_o), m_depth);
            win_en = (m_phase == 0) ? int'(clk_en_o) : win_en + int'(clk_en_o);
            if (m_phase == 99) check("R4", win_en, keep);
        end
    end

    task automatic set_cfg(logic m, int p, int l);
        mode_i = m;
        pct_i  = 7'(p);
        lvl_i  = 2'(l);
        repeat (100) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(clk_en_o), 1);
        check("R1", int'(depth_o), 0);
        rst_n = 1'b1;
        repeat (37) @(negedge clk);
        set_cfg(1'b0, 30, 0);
        set_cfg(1'b0, 100, 0);
        set_cfg(1'b0, 0, 0);
        set_cfg(1'b0, 127, 0);
        set_cfg(1'b0, 1, 0);
        set_cfg(1'b0, 99, 0);
        set_cfg(1'b0, 33, 0);
        set_cfg(1'b1, 0, 1);
        set_cfg(1'b1, 0, 2);
        set_cfg(1'b1, 0, 3);
        set_cfg(1'b1, 0, 0);
        // mid-window churn: only the value at phase 99 counts
        mode_i = 1'b0; pct_i = 7'd85;
        repeat (20) @(negedge clk);
        mode_i = 1'b1; lvl_i = 2'd3;
        repeat (20) @(negedge clk);
        mode_i = 1'b0; pct_i = 7'd60;
        repeat (260) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule